// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on one output line. The line carries no clock. Every bit is held for a fixed number of pulses of a single-cycle enable, `baud_tick`, which runs at sixteen times the bit rate by default. Word length, parity and stop length are set at run time through plain configuration inputs. The block samples these inputs when a character enters the shift stage.

A host writes characters through a simple strobe-and-data port. A small holding buffer sits in front of a shift register. The host can queue the next character while the current one is still on the line. `tx_ready` tells the host that there is room in the buffer. `hold_empty` and `shift_empty` report the two stages separately, so the host can tell "nothing queued" apart from "line completely quiet".

Top module: `async_tx`

## Requirements
- R1: After reset, and whenever the shift stage is idle, `txd` is high. Immediately after reset, `tx_ready`, `hold_empty` and `shift_empty` are all 1.
- R2: A frame is a low start bit, then the data bits least significant bit first, then the stop bits (high). The number of data bits is 5 + `cfg_len`, so `cfg_len` = 0, 1, 2, 3 gives 5, 6, 7, 8 bits. Bits of `wr_data` above the word length are never sent.
- R3: When `cfg_par_en` = 1, one parity bit follows the last data bit. With `cfg_par_odd` = 1 the count of ones in the data bits plus the parity bit is odd; with `cfg_par_odd` = 0 that count is even. When `cfg_par_en` = 0 no parity bit is sent.
- R4: With `cfg_stop_long` = 0 the stop phase lasts 16 ticks. With `cfg_stop_long` = 1 it lasts 32 ticks for 6, 7 and 8 bit words, and 24 ticks (one and a half bits) for 5 bit words.
- R5: The start bit, each data bit and the parity bit each last exactly 16 ticks. Neither `txd` nor `shift_empty` changes in a cycle that follows a clock edge without `baud_tick`.
- R6: A write accepted while `tx_ready` = 1 clears `hold_empty` from the next cycle on. On the first tick at which the shift stage is idle and the buffer holds a character, that character moves into the shift stage: `shift_empty` falls and `txd` goes low from the next cycle.
- R7: The holding buffer stores up to 2 characters. `tx_ready` is 1 exactly while fewer than 2 are stored.
- R8: A write while `tx_ready` = 0 is ignored. The characters already stored are sent unchanged, and no extra frame appears.
- R9: Characters are sent in the order they were written. The format of a frame is the one present on the configuration inputs when its character entered the shift stage; changes to those inputs during the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Single-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to send |
| cfg_len | input | 2 | Word length code, 5 + value bits |
| cfg_par_en | input | 1 | Send a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop_long | input | 1 | 0 = one stop bit; 1 = two stop bits, or one and a half for 5 bit words |
| txd | output | 1 | Serial output line, high when idle |
| tx_ready | output | 1 | Holding buffer can accept a write |
| hold_empty | output | 1 | Holding buffer is empty |
| shift_empty | output | 1 | Shift stage is idle |

## Verification
The properties assume that `baud_tick` is a single-cycle pulse sampled on the rising clock edge. They also assume that `wr_en` is only ever meant as one write per asserted cycle. They do not assume that the host respects `tx_ready`: writes into a full buffer are part of the checked behaviour. The bench changes every input on the falling edge only. It keeps the configuration steady from a write until that character's frame has started, except in the one test that changes the format during a frame on purpose. It runs the tick every cycle, one cycle in three, and not at all.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_START,
      TX_DATA,
      TX_PARITY,
      TX_STOP
   } tx_phase_e;

   typedef struct packed {
      logic [1:0] len;
      logic       par_en;
      logic       par_odd;
      logic       stop_long;
   } tx_fmt_t;

endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("async_tx_hold: DEPTH must be at least 1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("async_tx_hold: WIDTH must be at least 1");
      end
   endgenerate

   generate
      if (DEPTH == 1) begin : g_single
         logic [WIDTH-1:0] slot;
         logic             valid;
         logic             take_in;

         assign take_in = push && (!valid || pop);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot  <= '0;
               valid <= 1'b0;
            end else begin
               if (take_in) begin
                  slot  <= push_data;
                  valid <= 1'b1;
               end else if (pop) begin
                  valid <= 1'b0;
               end
            end
         end

         assign head  = slot;
         assign empty = !valid;
         assign full  = valid;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);
         localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
         localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

         logic [WIDTH-1:0] mem [DEPTH];
         logic [PTR_W-1:0] wptr;
         logic [PTR_W-1:0] rptr;
         logic [CNT_W-1:0] count;
         logic             do_push;
         logic             do_pop;

         assign do_push = push && (count != CNT_FULL);
         assign do_pop  = pop && (count != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wptr  <= '0;
               rptr  <= '0;
               count <= '0;
               for (int i = 0; i < DEPTH; i++) begin
                  mem[i] <= '0;
               end
            end else begin
               if (do_push) begin
                  mem[wptr] <= push_data;
                  wptr      <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
               end
               if (do_pop) begin
                  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
               end
               case ({do_push, do_pop})
                  2'b10:   count <= count + 1'b1;
                  2'b01:   count <= count - 1'b1;
                  default: count <= count;
               endcase
            end
         end

         assign head  = mem[rptr];
         assign empty = (count == '0);
         assign full  = (count == CNT_FULL);
      end
   endgenerate

endmodule

// File: rtl/async_tx_parity.sv
module async_tx_parity #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        len,
   input  logic              odd,
   output logic              par_bit
);

   localparam int MIN_W = DATA_W - 3;

   logic [DATA_W-1:0] keep;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         assign keep[i] = (i < MIN_W) ? 1'b1 : (32'(i) < 32'(MIN_W) + 32'(len));
      end
   endgenerate

   assign par_bit = (^(data & keep)) ^ odd;

endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
   import async_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ld_avail,
   input  logic [DATA_W-1:0] ld_data,
   input  tx_fmt_t           fmt,
   output logic              ld_take,
   output logic              line,
   output logic              idle
);

   localparam int MIN_W = DATA_W - 3;
   localparam int CNT_W = $clog2(2 * OVS);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] HALF3_LAST = CNT_W'(OVS + OVS / 2 - 1);
   localparam logic [CNT_W-1:0] TWO_LAST   = CNT_W'(2 * OVS - 1);

   generate
      if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("async_tx_shift: OVS must be even and at least 2");
      end
      if (DATA_W < 4) begin : g_bad_width
         $error("async_tx_shift: DATA_W must be at least 4");
      end
   endgenerate

   tx_phase_e         phase;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] sh;
   tx_fmt_t           fmt_q;
   logic              par_q;
   logic              par_in;
   logic [IDX_W-1:0]  idx_last;
   logic [CNT_W-1:0]  stop_last;
   logic              bit_end;

   async_tx_parity #(.DATA_W(DATA_W)) u_par (
      .data    (ld_data),
      .len     (fmt.len),
      .odd     (fmt.par_odd),
      .par_bit (par_in)
   );

   assign idx_last = IDX_W'(MIN_W - 1) + IDX_W'(fmt_q.len);
   assign bit_end  = (cnt == BIT_LAST);

   always_comb begin
      if (!fmt_q.stop_long) begin
         stop_last = BIT_LAST;
      end else if (fmt_q.len == 2'd0) begin
         stop_last = HALF3_LAST;
      end else begin
         stop_last = TWO_LAST;
      end
   end

   assign ld_take = tick && (phase == TX_IDLE) && ld_avail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= TX_IDLE;
         cnt   <= '0;
         idx   <= '0;
         sh    <= '0;
         fmt_q <= '0;
         par_q <= 1'b0;
      end else if (tick) begin
         case (phase)
            TX_IDLE: begin
               if (ld_avail) begin
                  phase <= TX_START;
                  cnt   <= '0;
                  sh    <= ld_data;
                  fmt_q <= fmt;
                  par_q <= par_in;
               end
            end
            TX_START: begin
               if (bit_end) begin
                  cnt   <= '0;
                  idx   <= '0;
                  phase <= TX_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            TX_DATA: begin
               if (bit_end) begin
                  cnt <= '0;
                  sh  <= sh >> 1;
                  if (idx == idx_last) begin
                     phase <= fmt_q.par_en ? TX_PARITY : TX_STOP;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            TX_PARITY: begin
               if (bit_end) begin
                  cnt   <= '0;
                  phase <= TX_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            TX_STOP: begin
               if (cnt == stop_last) begin
                  cnt   <= '0;
                  phase <= TX_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: phase <= TX_IDLE;
         endcase
      end
   end

   always_comb begin
      case (phase)
         TX_START:  line = 1'b0;
         TX_DATA:   line = sh[0];
         TX_PARITY: line = par_q;
         default:   line = 1'b1;
      endcase
   end

   assign idle = (phase == TX_IDLE);

endmodule

// File: rtl/async_tx.sv
module async_tx
   import async_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_stop_long,
   output logic              txd,
   output logic              tx_ready,
   output logic              hold_empty,
   output logic              shift_empty
);

   logic [DATA_W-1:0] head;
   logic              buf_empty;
   logic              buf_full;
   logic              take;
   tx_fmt_t           fmt;

   assign fmt = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                  stop_long: cfg_stop_long};

   async_tx_hold #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_en),
      .push_data (wr_data),
      .pop       (take),
      .head      (head),
      .empty     (buf_empty),
      .full      (buf_full)
   );

   async_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .ld_avail (!buf_empty),
      .ld_data  (head),
      .fmt      (fmt),
      .ld_take  (take),
      .line     (txd),
      .idle     (shift_empty)
   );

   assign tx_ready   = !buf_full;
   assign hold_empty = buf_empty;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic wr_en,
   input logic txd,
   input logic tx_ready,
   input logic hold_empty,
   input logic shift_empty
);

   // R1
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_empty |-> txd);

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_empty) |-> !txd);

   // R5
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> ($stable(txd) && $stable(shift_empty)));

   // R6
   write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tx_ready) |=> !hold_empty);

   // R6
   load_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_tick && shift_empty && !hold_empty) |=> (!shift_empty && !txd));

   // R7
   empty_means_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_empty |-> tx_ready);

   // R8
   full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tx_ready && !baud_tick) |=> !tx_ready);

endmodule

bind async_tx async_tx_chk u_async_tx_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .baud_tick   (baud_tick),
   .wr_en       (wr_en),
   .txd         (txd),
   .tx_ready    (tx_ready),
   .hold_empty  (hold_empty),
   .shift_empty (shift_empty)
);

// File: tb/test_async_tx.sv
module test_async_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_stop_long = 1'b0;
   logic       txd;
   logic       tx_ready;
   logic       hold_empty;
   logic       shift_empty;

   int checks = 0;
   int errors = 0;
   int tick_div = 1;
   int div_cnt = 0;
   logic rec_clr = 1'b0;
   logic rec_bits [1024];
   int rec_n = 0;

   always #10 clk = ~clk;

   async_tx i_async_tx (
      .clk           (clk),
      .rst_n         (rst_n),
      .baud_tick     (baud_tick),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .cfg_len       (cfg_len),
      .cfg_par_en    (cfg_par_en),
      .cfg_par_odd   (cfg_par_odd),
      .cfg_stop_long (cfg_stop_long),
      .txd           (txd),
      .tx_ready      (tx_ready),
      .hold_empty    (hold_empty),
      .shift_empty   (shift_empty)
   );

   // tick generator: tick_div 0 = never, N = one cycle in N
   always @(negedge clk) begin
      if (tick_div == 0) begin
         baud_tick = 1'b0;
         div_cnt = 0;
      end else if (div_cnt >= tick_div - 1) begin
         baud_tick = 1'b1;
         div_cnt = 0;
      end else begin
         baud_tick = 1'b0;
         div_cnt = div_cnt + 1;
      end
   end

   // recorder of the line while a frame is in progress
   always @(negedge clk) begin
      if (rec_clr) begin
         rec_n = 0;
      end else if (rst_n && !shift_empty && rec_n < 1024) begin
         rec_bits[rec_n] = txd;
         rec_n = rec_n + 1;
      end
   end

   // {data, len, par_en, par_odd, stop_long}
   localparam logic [12:0] VEC [8] = '{
      {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0},
      {8'h3C, 2'd3, 1'b1, 1'b0, 1'b0},
      {8'h3C, 2'd3, 1'b1, 1'b1, 1'b1},
      {8'h1F, 2'd0, 1'b1, 1'b1, 1'b1},
      {8'hFF, 2'd0, 1'b1, 1'b0, 1'b0},
      {8'h5A, 2'd1, 1'b0, 1'b0, 1'b1},
      {8'h81, 2'd2, 1'b1, 1'b1, 1'b0},
      {8'h00, 2'd3, 1'b1, 1'b1, 1'b1}
   };

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int stop_ticks(input logic [1:0] len, input logic sl);
      if (!sl) return 16;
      return (len == 2'd0) ? 24 : 32;
   endfunction

   function automatic int frame_ticks(input logic [1:0] len, input logic p, input logic sl);
      return 16 * (1 + 5 + int'(len) + int'(p)) + stop_ticks(len, sl);
   endfunction

   // compare a recorded frame at offset base, mult cycles per tick
   task automatic check_frame(input int base, input int mult, input logic [7:0] d,
                              input logic [1:0] len, input logic p, input logic o,
                              input string tag);
      int nb;
      int bad;
      int bad_at;
      logic exp_bit;
      logic got;
      logic ones;
      nb = 5 + int'(len);
      bad = 0;
      bad_at = -1;
      ones = 1'b0;
      for (int k = 0; k < 1 + nb + int'(p) + 1; k++) begin
         if (k == 0) begin
            exp_bit = 1'b0;
         end else if (k <= nb) begin
            exp_bit = d[k-1];
            ones = ones ^ d[k-1];
         end else if (p && k == nb + 1) begin
            exp_bit = ones ^ o;
         end else begin
            exp_bit = 1'b1;
         end
         got = rec_bits[base + mult * (16 * k + 8)];
         if (got !== exp_bit) begin
            bad++;
            if (bad_at < 0) bad_at = k;
         end
      end
      check(bad == 0, tag, bad_at, -1);
   endtask

   task automatic wait_quiet();
      @(negedge clk);
      while (!(shift_empty && hold_empty)) @(negedge clk);
   endtask

   task automatic clear_rec();
      rec_clr = 1'b1;
      @(negedge clk);
      rec_clr = 1'b0;
   endtask

   task automatic write_char(input logic [7:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      logic [12:0] v;
      int len_exp;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
      check(tx_ready === 1'b1, "R1 tx_ready after reset", int'(tx_ready), 1);
      check(hold_empty === 1'b1, "R1 hold_empty after reset", int'(hold_empty), 1);
      check(shift_empty === 1'b1, "R1 shift_empty after reset", int'(shift_empty), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table of formats, one tick per cycle
      for (int i = 0; i < 8; i++) begin
         v = VEC[i];
         cfg_len = v[4:3];
         cfg_par_en = v[2];
         cfg_par_odd = v[1];
         cfg_stop_long = v[0];
         clear_rec();
         write_char(v[12:5]);
         wait_quiet();
         len_exp = frame_ticks(v[4:3], v[2], v[0]);
         check(rec_n == len_exp, "R4 R5 frame length", rec_n, len_exp);
         check_frame(0, 1, v[12:5], v[4:3], v[2], v[1], "R2 R3 frame bits");
      end

      // R5: no tick, no progress
      tick_div = 0;
      clear_rec();
      cfg_len = 2'd0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop_long = 1'b0;
      write_char(8'h0B);
      repeat (10) @(negedge clk);
      check(shift_empty === 1'b1, "R5 shift_empty without tick", int'(shift_empty), 1);
      check(txd === 1'b1, "R5 txd without tick", int'(txd), 1);
      check(hold_empty === 1'b0, "R6 hold_empty after write", int'(hold_empty), 0);
      tick_div = 1;
      wait_quiet();
      check(rec_n == frame_ticks(2'd0, 1'b0, 1'b0), "R5 frame after ticks resume",
            rec_n, frame_ticks(2'd0, 1'b0, 1'b0));

      // R5: sparse ticks, one in three cycles
      tick_div = 3;
      clear_rec();
      write_char(8'h16);
      wait_quiet();
      check(rec_n == 3 * frame_ticks(2'd0, 1'b0, 1'b0), "R5 sparse tick length",
            rec_n, 3 * frame_ticks(2'd0, 1'b0, 1'b0));
      check_frame(0, 3, 8'h16, 2'd0, 1'b0, 1'b0, "R5 sparse tick bits");
      tick_div = 1;
      repeat (3) @(negedge clk);

      // R9: format change during a frame has no effect
      clear_rec();
      write_char(8'h15);
      while (shift_empty) @(negedge clk);
      cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_stop_long = 1'b1;
      wait_quiet();
      check(rec_n == frame_ticks(2'd0, 1'b0, 1'b0), "R9 format latched at load",
            rec_n, frame_ticks(2'd0, 1'b0, 1'b0));
      check_frame(0, 1, 8'h15, 2'd0, 1'b0, 1'b0, "R9 latched frame bits");

      // R6 R7 R8 R9: back-to-back writes, overflow write
      cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop_long = 1'b0;
      clear_rec();
      wr_en = 1'b1; wr_data = 8'hC3;
      @(negedge clk);
      check(hold_empty === 1'b0, "R6 hold_empty after write", int'(hold_empty), 0);
      check(shift_empty === 1'b1, "R6 shift_empty before load", int'(shift_empty), 1);
      wr_data = 8'h96;
      @(negedge clk);
      check(shift_empty === 1'b0, "R6 shift_empty after load", int'(shift_empty), 0);
      wr_data = 8'h4E;
      @(negedge clk);
      check(tx_ready === 1'b0, "R7 ready low when two stored", int'(tx_ready), 0);
      wr_data = 8'hFF;
      @(negedge clk);
      wr_en = 1'b0;
      check(tx_ready === 1'b0, "R8 still full after ignored write", int'(tx_ready), 0);
      wait_quiet();
      len_exp = frame_ticks(2'd3, 1'b0, 1'b0);
      check(rec_n == 3 * len_exp, "R8 no extra frame", rec_n, 3 * len_exp);
      check_frame(0, 1, 8'hC3, 2'd3, 1'b0, 1'b0, "R9 first frame in order");
      check_frame(len_exp, 1, 8'h96, 2'd3, 1'b0, 1'b0, "R9 second frame in order");
      check_frame(2 * len_exp, 1, 8'h4E, 2'd3, 1'b0, 1'b0, "R8 third frame unchanged");
      check(tx_ready === 1'b1 && txd === 1'b1, "R1 R7 quiet after drain",
            int'({tx_ready, txd}), 3);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #3000000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule